// File: doc/BRIEF.md
# Indexed Configuration Window

This block gives a host a byte-wide view of a 256-entry configuration space through just two I/O addresses. A write to the first address (the base) picks an entry by loading an 8-bit pointer. Any access to either address then reaches the entry that the pointer selects. Reads at either address return that entry. The pointer itself cannot be read back. Writes at the second address (base + 1) store into the selected entry, but only when a fixed protection map allows it. Two entries are pinned: each accepts only one byte value and drops every other value.

The whole window is gated by an enable that a neighbouring bridge controls. When the bridge's configuration space takes a write at offset 0x85, bit 1 of that byte is sampled and becomes the window enable. While the window is off, reads return 0xFF, writes do nothing, and both the pointer and the stored entries keep their values. Only single-byte accesses exist. The I/O side uses plain strobes with no back-pressure: every strobe is taken in the cycle it appears. Each read strobe gets exactly one registered answer one cycle later.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is disabled and the pointer is 0x00. Entries hold these values: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE. Every other entry holds 0x00.
- R2: A bridge write (`brg_wr`) with `brg_off` equal to 0x85 sets the window enable to `brg_en_lane` (bit 1 of the bridge byte) at that clock edge. Bridge writes to any other offset leave the enable unchanged.
- R3: With the window enabled, a write strobe at the base address (0x3F0) loads `io_wdata` into the pointer at that clock edge.
- R4: With the window enabled, a write strobe at base + 1 (0x3F1) stores `io_wdata` into the entry the pointer selects, when that entry is writable. The writable entries are 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC, plus 0xE7 and 0xE8 as limited by R6.
- R5: Writes at base + 1 to any other entry are dropped. These entries are 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB and 0xFD–0xFF.
- R6: Entry 0xE7 accepts a write only of 0xFE, and entry 0xE8 accepts a write only of 0xBE. Any other byte written to them is dropped.
- R7: With the window enabled, a read strobe at either window address returns the selected entry on `io_rdata` one cycle after the strobe. The pointer value is never returned.
- R8: With the window disabled, a read strobe returns 0xFF one cycle later. Write strobes change neither the pointer nor any entry.
- R9: Strobes at addresses outside the two-byte window have no effect, and a read there returns 0xFF one cycle later. `io_rdata` holds its value between read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the current strobe |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte, valid the cycle after `io_rd` |
| brg_wr | input | 1 | Bridge configuration write strobe |
| brg_off | input | 8 | Bridge configuration byte offset |
| brg_en_lane | input | 1 | Bit 1 of the bridge configuration write byte |

## Verification
A full directed sweep after reset reads every pointer value. This separates the six non-zero defaults from the cleared entries and shows that the pointer never leaks onto the read path. A second sweep writes 0x5A at every pointer value and reads it back. Only the open entries take the byte, so this tells the protection map apart from a plain memory, and it shows the pinned pair dropping a foreign byte. Random traffic follows: pointer loads leaning toward the upper entries, data bytes that often equal 0xFE or 0xBE, bridge writes that toggle the enable or miss the offset, and strobes outside the window. Each read is compared with a bench model, which separates the disabled, outside-window and pinned-value answers from normal entry reads.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int IDX_W   = 8;
  localparam int DATA_W  = 8;
  localparam int ENTRIES = 1 << IDX_W;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [DATA_W-1:0] byte_t;

  // Entries that software may never change.
  function automatic logic idx_locked(input idx_t i);
    logic lk;
    lk = (i <= 8'hDF);
    lk = lk | (i inside {8'hE4, 8'hE5, 8'hF3, 8'hF5, 8'hF7});
    lk = lk | ((i >= 8'hE9) && (i <= 8'hED));
    lk = lk | ((i >= 8'hF9) && (i <= 8'hFB));
    lk = lk | (i >= 8'hFD);
    return lk;
  endfunction

  // Entries that accept exactly one byte value.
  function automatic logic idx_pinned(input idx_t i);
    return (i == 8'hE7) || (i == 8'hE8);
  endfunction

  function automatic byte_t pin_value(input idx_t i);
    return (i == 8'hE7) ? 8'hFE : 8'hBE;
  endfunction

  function automatic byte_t reset_value(input idx_t i);
    byte_t v;
    case (i)
      8'hE0:   v = 8'h3C;
      8'hE2:   v = 8'h03;
      8'hE3:   v = 8'hFC;
      8'hE6:   v = 8'hDE;
      8'hE7:   v = 8'hFE;
      8'hE8:   v = 8'hBE;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sio_win_gate.sv
module sio_win_gate #(
  parameter int OFF_W   = 8,
  parameter logic [OFF_W-1:0] CTRL_OFF = 8'h85
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brg_wr,
  input  logic [OFF_W-1:0] brg_off,
  input  logic             brg_en_lane,
  output logic             win_en
);

  logic hit;
  assign hit = brg_wr && (brg_off == CTRL_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   win_en <= 1'b0;
    else if (hit) win_en <= brg_en_lane;
  end

endmodule

// File: rtl/sio_wr_policy.sv
module sio_wr_policy
  import sio_cfg_pkg::*;
(
  input  idx_t  idx,
  input  byte_t data,
  output logic  accept
);

  always_comb begin
    if (idx_locked(idx))      accept = 1'b0;
    else if (idx_pinned(idx)) accept = (data == pin_value(idx));
    else                      accept = 1'b1;
  end

endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
  import sio_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  idx_t  wr_idx,
  input  byte_t wr_data,
  input  idx_t  rd_idx,
  output byte_t rd_data
);

  byte_t ent [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    localparam idx_t  GI  = idx_t'(g);
    localparam byte_t RST = reset_value(GI);
    if (idx_locked(GI)) begin : g_const
      assign ent[g] = RST;
    end else begin : g_reg
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      q <= RST;
        else if (wr_en && wr_idx == GI)  q <= wr_data;
      end
      assign ent[g] = q;
    end
  end

  assign rd_data = ent[rd_idx];

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] CTRL_OFF = 8'h85,
  parameter logic [DATA_W-1:0] IDLE_RD = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              brg_wr,
  input  logic [OFF_W-1:0]  brg_off,
  input  logic              brg_en_lane
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

  logic  win_en_q;
  idx_t  idx_q;
  byte_t bank_rd;
  logic  wr_ok;
  logic  hit_idx, hit_dat, hit_any;
  logic  data_we;

  assign hit_idx = (io_addr == BASE_ADDR);
  assign hit_dat = (io_addr == DATA_ADDR);
  assign hit_any = hit_idx || hit_dat;

  sio_win_gate #(.OFF_W(OFF_W), .CTRL_OFF(CTRL_OFF)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .brg_wr      (brg_wr),
    .brg_off     (brg_off),
    .brg_en_lane (brg_en_lane),
    .win_en      (win_en_q)
  );

  sio_wr_policy u_policy (
    .idx    (idx_q),
    .data   (io_wdata),
    .accept (wr_ok)
  );

  assign data_we = win_en_q && io_wr && hit_dat && wr_ok;

  sio_cfg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (data_we),
    .wr_idx  (idx_q),
    .wr_data (io_wdata),
    .rd_idx  (idx_q),
    .rd_data (bank_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (win_en_q && io_wr && hit_idx)
      idx_q <= io_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      io_rdata <= IDLE_RD;
    else if (io_rd)
      io_rdata <= (win_en_q && hit_any) ? bank_rd : IDLE_RD;
  end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] CTRL_OFF = 8'h85
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              brg_wr,
  input logic [OFF_W-1:0]  brg_off,
  input logic              brg_en_lane,
  input logic              win_en,
  input logic [7:0]        idx,
  input logic [7:0]        bank_rd
);

  logic in_win;
  assign in_win = (io_addr == BASE_ADDR) || (io_addr == BASE_ADDR + ADDR_W'(1));

  assert_en_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    brg_wr && brg_off == CTRL_OFF |=> win_en == $past(brg_en_lane));

  assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(brg_wr && brg_off == CTRL_OFF) |=> $stable(win_en));

  assert_idx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_en && io_wr && io_addr == BASE_ADDR |=> idx == $past(io_wdata));

  assert_pin_e7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idx == 8'hE7 |-> bank_rd == 8'hFE);

  assert_pin_e8_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idx == 8'hE8 |-> bank_rd == 8'hBE);

  assert_rd_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_en && io_rd && in_win |=> io_rdata == $past(bank_rd));

  assert_dis_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en && io_rd |=> io_rdata == 8'hFF);

  assert_dis_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |=> $stable(idx));

  assert_miss_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && !in_win |=> io_rdata == 8'hFF);

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .OFF_W(OFF_W), .CTRL_OFF(CTRL_OFF)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_addr     (io_addr),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .brg_wr      (brg_wr),
  .brg_off     (brg_off),
  .brg_en_lane (brg_en_lane),
  .win_en      (win_en_q),
  .idx         (idx_q),
  .bank_rd     (bank_rd)
);

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        brg_wr = 1'b0;
  logic [7:0]  brg_off = '0;
  logic        brg_en_lane = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] m_cfg [256];
  logic [7:0] m_idx;
  bit         m_en;

  always #10 clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .brg_wr(brg_wr), .brg_off(brg_off),
    .brg_en_lane(brg_en_lane)
  );

  function automatic bit b_open(int i);
    return i inside {'hE0, 'hE1, 'hE2, 'hE3, 'hE6, 'hE7, 'hE8, 'hEE, 'hEF,
                     'hF0, 'hF1, 'hF2, 'hF4, 'hF6, 'hF8, 'hFC};
  endfunction

  function automatic bit b_accept(int i, logic [7:0] d);
    if (!b_open(i)) return 0;
    if (i == 'hE7) return d == 8'hFE;
    if (i == 'hE8) return d == 8'hBE;
    return 1;
  endfunction

  function automatic logic [7:0] b_default(int i);
    case (i)
      'hE0: return 8'h3C;
      'hE2: return 8'h03;
      'hE3: return 8'hFC;
      'hE6: return 8'hDE;
      'hE7: return 8'hFE;
      'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string b_tag(logic [15:0] a);
    if (!(a == 16'h03F0 || a == 16'h03F1)) return "R9";
    if (!m_en) return "R8";
    if (m_idx == 8'hE7 || m_idx == 8'hE8) return "R6";
    if (!b_open(m_idx)) return "R5";
    return "R4/R7";
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (m_en) begin
      if (a == 16'h03F0) m_idx = d;
      else if (a == 16'h03F1 && b_accept(m_idx, d)) m_cfg[m_idx] = d;
    end
  endtask

  task automatic io_read(logic [15:0] a, string tag);
    logic [7:0] exp;
    exp = (m_en && (a == 16'h03F0 || a == 16'h03F1)) ? m_cfg[m_idx] : 8'hFF;
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    check(tag, io_rdata, exp);
  endtask

  task automatic bridge(logic [7:0] off, logic lane);
    @(negedge clk);
    brg_off = off; brg_en_lane = lane; brg_wr = 1'b1;
    @(negedge clk);
    brg_wr = 1'b0;
    if (off == 8'h85) m_en = lane;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0C1F));
    for (int i = 0; i < 256; i++) m_cfg[i] = b_default(i);
    m_idx = 8'h00; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: window starts disabled, reads give 0xFF
    check("R1 rdata at reset", io_rdata, 8'hFF);
    io_read(16'h03F1, "R1");
    // R8: disabled writes are dropped
    io_write(16'h03F0, 8'hE0);
    io_write(16'h03F1, 8'h77);
    // R2: other offset does not enable
    bridge(8'h84, 1'b1);
    io_read(16'h03F1, "R2");
    bridge(8'h85, 1'b1);
    // R1: pointer still 0x00, entry 0 reads 0x00
    io_read(16'h03F1, "R1");
    // R1/R7: sweep of defaults, alternate read address
    for (int i = 0; i < 256; i++) begin
      io_write(16'h03F0, 8'(i));
      io_read((i % 2) ? 16'h03F1 : 16'h03F0, "R1");
    end
    // R3/R7: pointer not read back
    io_write(16'h03F0, 8'h10);
    io_read(16'h03F0, "R3");
    // R4/R5/R6: write 0x5A everywhere, read back
    for (int i = 0; i < 256; i++) begin
      io_write(16'h03F0, 8'(i));
      io_write(16'h03F1, 8'h5A);
      io_read(16'h03F1, b_tag(16'h03F1));
    end
    // R6: pinned values accepted
    io_write(16'h03F0, 8'hE7); io_write(16'h03F1, 8'hFE); io_read(16'h03F1, "R6");
    io_write(16'h03F0, 8'hE8); io_write(16'h03F1, 8'hBE); io_read(16'h03F1, "R6");
    // R8: contents kept while disabled
    io_write(16'h03F0, 8'hF4); io_write(16'h03F1, 8'hC3);
    bridge(8'h85, 1'b0);
    io_write(16'h03F0, 8'hE0); io_write(16'h03F1, 8'h11);
    io_read(16'h03F1, "R8");
    bridge(8'h85, 1'b1);
    io_read(16'h03F1, "R8");
    // R9: outside window
    io_write(16'h03F2, 8'h00);
    io_read(16'h03F2, "R9");
    io_read(16'h03F1, "R9");

    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 99);
      if (op < 6) begin
        bridge(($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h85,
               ($urandom_range(0, 4) != 0));
      end else if (op < 30) begin
        d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(224, 255));
        io_write(16'h03F0, d);
      end else if (op < 55) begin
        case ($urandom_range(0, 3))
          0: d = 8'hFE;
          1: d = 8'hBE;
          default: d = 8'($urandom);
        endcase
        io_write(16'h03F1, d);
      end else if (op < 92) begin
        logic [15:0] a;
        a = ($urandom_range(0, 1) == 0) ? 16'h03F0 : 16'h03F1;
        io_read(a, b_tag(a));
      end else begin
        logic [15:0] a;
        a = 16'($urandom_range(0, 16'h03EF));
        if ($urandom_range(0, 1) == 0) io_write(a, 8'($urandom));
        else io_read(a, "R9");
      end
    end
    finish_run();
  end

endmodule